// File: doc/BRIEF.md
# Supply Qualification and Host Interrupt Pulser

This block watches the two supply comparator flags of a charger front end and decides when the input power path may close. The input counts as usable only while it is both above the under-voltage threshold and below the over-voltage threshold. The path opens in the same cycle that either flag says the input is out of range. It closes again only after the input has stayed in range for a programmable number of millisecond ticks.

A separate debounce stage reports input status changes to the host. A change is reported only after the new state has held for a settling time in ticks. The report, together with four event strobes from other blocks (charge complete, charge status change, new fault record and watchdog expiry), is turned into active-low pulses of fixed length on the interrupt line. Each event source has its own mask bit. An event that is not masked while a pulse is already running is held as a pending bit and later gets its own pulse. Whenever the path closes or a pulse starts, the block asks the register file to force the watchdog period to its short code. The next register write withdraws that request.

There are two state machines. The path qualifier has the states Q_OFF, Q_WAIT and Q_ON:
- Q_OFF goes to Q_WAIT when the input comes into range.
- Q_WAIT goes back to Q_OFF when the input leaves range, and goes to Q_ON on the last qualification tick.
- Q_ON goes to Q_OFF when the input leaves range.

The pulser has the states P_IDLE, P_LOW and P_GAP:
- P_IDLE goes to P_LOW when any bit is pending.
- P_LOW goes to P_GAP after the pulse length.
- P_GAP goes to P_IDLE after the gap length.

Top module: `supply_irq_top`

## Requirements
- R1: The input is in range only when `above_uvlo` and `below_ovlo` are both 1. While the input is out of range, `path_en` is 0 in that same cycle, with no register delay.
- R2: `path_en` rises only after the input has been in range without a break for QUAL_TICKS ticks of `tick_ms`. Any out-of-range cycle restarts the count from zero.
- R3: A change of the in-range state is reported only after the new state has held for STABLE_TICKS ticks. A state that returns before then produces no pulse.
- R4: Every interrupt pulse holds `int_n` low for exactly PULSE_CYC clock cycles. `int_n` is 1 at all other times.
- R5: A one-cycle strobe on `evt_done`, `evt_stat`, `evt_fault` or `evt_wdt` produces exactly one pulse.
- R6: Mask bit positions are: bit 0 input status report, bit 1 charge complete, bit 2 status change, bit 3 fault, bit 4 watchdog expiry. When a mask bit is 1, its event is discarded and `int_n` stays 1.
- R7: Events that arrive while a pulse is active, or in the same cycle as another event, are kept pending. Each one is issued as its own pulse, with at least GAP_CYC cycles of `int_n` high between pulses.
- R8: `wdt_force` becomes 1 when the path closes (`path_en` rises) and when a pulse starts. A cycle with `reg_wr` set clears it, unless a set condition occurs in that same cycle.
- R9: After reset, `path_en` is 0, `int_n` is 1 and `wdt_force` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_ms | input | 1 | One-cycle strobe once per millisecond |
| above_uvlo | input | 1 | Comparator: input above under-voltage threshold |
| below_ovlo | input | 1 | Comparator: input below over-voltage threshold |
| evt_done | input | 1 | Charge-complete strobe |
| evt_stat | input | 1 | Charge-status-change strobe |
| evt_fault | input | 1 | New-fault-record strobe |
| evt_wdt | input | 1 | Watchdog-expiry strobe |
| irq_mask | input | 5 | Per-event mask, 1 suppresses |
| reg_wr | input | 1 | Any register write; withdraws the watchdog force |
| path_en | output | 1 | Input power path enable |
| int_n | output | 1 | Active-low interrupt to host |
| wdt_force | output | 1 | Request to force the watchdog to its short code |

## Verification
The assertions assume that the comparator flags are synchronous to `clk`. They also assume that event strobes last one cycle, and that `tick_ms` never comes in two cycles in a row, because the pulse-length and gap checks count cycles rather than ticks. The stimulus changes the flags and strobes only on falling edges, fires strobes for a single cycle, and derives ticks from a free-running divide-by-four counter. This keeps the stimulus inside those assumptions.

// File: rtl/supply_irq_pkg.sv
package supply_irq_pkg;

    localparam int NUM_EVT = 5;

    localparam int EV_INPUT = 0;
    localparam int EV_DONE  = 1;
    localparam int EV_STAT  = 2;
    localparam int EV_FAULT = 3;
    localparam int EV_WDT   = 4;

    typedef enum logic [1:0] {
        Q_OFF  = 2'd0,
        Q_WAIT = 2'd1,
        Q_ON   = 2'd2
    } qual_state_t;

    typedef enum logic [1:0] {
        P_IDLE = 2'd0,
        P_LOW  = 2'd1,
        P_GAP  = 2'd2
    } pulse_state_t;

endpackage

// File: rtl/supply_path_qual.sv
module supply_path_qual
    import supply_irq_pkg::*;
#(
    parameter int QUAL_TICKS = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_ms,
    input  logic in_ok,
    output logic path_en,
    output logic path_rise
);
    localparam int CW = $clog2(QUAL_TICKS + 1);

    qual_state_t st, st_nx;
    logic [CW-1:0] cnt, cnt_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= Q_OFF;
            cnt <= '0;
        end else begin
            st  <= st_nx;
            cnt <= cnt_nx;
        end
    end

    always_comb begin
        st_nx     = st;
        cnt_nx    = cnt;
        path_rise = 1'b0;
        unique case (st)
            Q_OFF: begin
                cnt_nx = '0;
                if (in_ok) st_nx = Q_WAIT;
            end
            Q_WAIT: begin
                if (!in_ok) begin
                    st_nx  = Q_OFF;
                    cnt_nx = '0;
                end else if (tick_ms) begin
                    if (cnt == CW'(QUAL_TICKS - 1)) begin
                        st_nx     = Q_ON;
                        path_rise = 1'b1;
                    end else begin
                        cnt_nx = cnt + 1'b1;
                    end
                end
            end
            Q_ON: begin
                if (!in_ok) st_nx = Q_OFF;
            end
            default: st_nx = Q_OFF;
        endcase
    end

    always_comb begin
        path_en = (st == Q_ON) && in_ok;
    end

endmodule

// File: rtl/supply_stable_mon.sv
module supply_stable_mon #(
    parameter int STABLE_TICKS = 70
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_ms,
    input  logic in_ok,
    output logic chg
);
    localparam int CW = $clog2(STABLE_TICKS + 1);

    logic          rep;
    logic [CW-1:0] cnt;
    logic          differ, settle;

    always_comb begin
        differ = (in_ok != rep);
        settle = differ && tick_ms && (cnt == CW'(STABLE_TICKS - 1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rep <= 1'b0;
            cnt <= '0;
            chg <= 1'b0;
        end else begin
            chg <= settle;
            if (!differ) begin
                cnt <= '0;
            end else if (settle) begin
                rep <= in_ok;
                cnt <= '0;
            end else if (tick_ms) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/irq_pulser.sv
module irq_pulser
    import supply_irq_pkg::*;
#(
    parameter int PULSE_CYC = 250,
    parameter int GAP_CYC   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt,
    input  logic [NUM_EVT-1:0] mask,
    output logic               int_n,
    output logic               start
);
    localparam int MAXC = (PULSE_CYC > GAP_CYC) ? PULSE_CYC : GAP_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    pulse_state_t st, st_nx;
    logic [CW-1:0] cnt, cnt_nx;
    logic [NUM_EVT-1:0] pend, grant;

    always_comb begin
        grant = pend & (~pend + 1'b1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st   <= P_IDLE;
            cnt  <= '0;
            pend <= '0;
        end else begin
            st   <= st_nx;
            cnt  <= cnt_nx;
            pend <= (pend & ~(start ? grant : '0)) | (evt & ~mask);
        end
    end

    always_comb begin
        st_nx  = st;
        cnt_nx = cnt;
        start  = 1'b0;
        unique case (st)
            P_IDLE: begin
                cnt_nx = '0;
                if (|pend) begin
                    st_nx = P_LOW;
                    start = 1'b1;
                end
            end
            P_LOW: begin
                if (cnt == CW'(PULSE_CYC - 1)) begin
                    st_nx  = P_GAP;
                    cnt_nx = '0;
                end else begin
                    cnt_nx = cnt + 1'b1;
                end
            end
            P_GAP: begin
                if (cnt == CW'(GAP_CYC - 1)) begin
                    st_nx  = P_IDLE;
                    cnt_nx = '0;
                end else begin
                    cnt_nx = cnt + 1'b1;
                end
            end
            default: st_nx = P_IDLE;
        endcase
    end

    always_comb begin
        int_n = (st != P_LOW);
    end

endmodule

// File: rtl/supply_irq_top.sv
module supply_irq_top
    import supply_irq_pkg::*;
#(
    parameter int QUAL_TICKS   = 20,
    parameter int STABLE_TICKS = 70,
    parameter int PULSE_CYC    = 250,
    parameter int GAP_CYC      = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_ms,
    input  logic       above_uvlo,
    input  logic       below_ovlo,
    input  logic       evt_done,
    input  logic       evt_stat,
    input  logic       evt_fault,
    input  logic       evt_wdt,
    input  logic [4:0] irq_mask,
    input  logic       reg_wr,
    output logic       path_en,
    output logic       int_n,
    output logic       wdt_force
);
    logic in_ok, path_rise, in_chg, pstart;
    logic [NUM_EVT-1:0] evt_vec;

    always_comb begin
        in_ok             = above_uvlo && below_ovlo;
        evt_vec           = '0;
        evt_vec[EV_INPUT] = in_chg;
        evt_vec[EV_DONE]  = evt_done;
        evt_vec[EV_STAT]  = evt_stat;
        evt_vec[EV_FAULT] = evt_fault;
        evt_vec[EV_WDT]   = evt_wdt;
    end

    supply_path_qual #(.QUAL_TICKS(QUAL_TICKS)) u_qual (
        .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .in_ok(in_ok),
        .path_en(path_en), .path_rise(path_rise)
    );

    supply_stable_mon #(.STABLE_TICKS(STABLE_TICKS)) u_stab (
        .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .in_ok(in_ok),
        .chg(in_chg)
    );

    irq_pulser #(.PULSE_CYC(PULSE_CYC), .GAP_CYC(GAP_CYC)) u_pulse (
        .clk(clk), .rst_n(rst_n), .evt(evt_vec), .mask(irq_mask),
        .int_n(int_n), .start(pstart)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  wdt_force <= 1'b0;
        else if (path_rise || pstart) wdt_force <= 1'b1;
        else if (reg_wr)             wdt_force <= 1'b0;
    end

endmodule

// File: rtl/supply_irq_chk.sv
module supply_irq_chk #(
    parameter int PULSE_CYC = 250
) (
    input logic clk,
    input logic rst_n,
    input logic above_uvlo,
    input logic below_ovlo,
    input logic path_en,
    input logic int_n,
    input logic wdt_force
);
    localparam int CW = $clog2(PULSE_CYC + 2);

    logic [CW-1:0] low_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               low_run <= '0;
        else if (int_n)           low_run <= '0;
        else if (low_run != '1)   low_run <= low_run + 1'b1;
    end

    // R1
    path_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(above_uvlo && below_ovlo) |-> !path_en);

    // R2
    path_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(path_en) |-> (above_uvlo && below_ovlo) && $past(above_uvlo && below_ovlo));

    // R4
    pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(int_n) |-> low_run == CW'(PULSE_CYC));

    // R7
    pulse_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(int_n) |=> int_n);

    // R8
    wdt_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(int_n) |-> wdt_force);

endmodule

bind supply_irq_top supply_irq_chk #(.PULSE_CYC(PULSE_CYC)) u_chk (
    .clk(clk), .rst_n(rst_n), .above_uvlo(above_uvlo), .below_ovlo(below_ovlo),
    .path_en(path_en), .int_n(int_n), .wdt_force(wdt_force)
);

// File: tb/supply_irq_top_tb.sv
module supply_irq_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int QUAL   = 4;
    localparam int STABLE = 8;
    localparam int PULSE  = 5;
    localparam int GAP    = 2;

    logic clk = 1'b0, rst_n = 1'b0, tick_ms = 1'b0;
    logic above_uvlo = 1'b0, below_ovlo = 1'b1;
    logic evt_done = 1'b0, evt_stat = 1'b0, evt_fault = 1'b0, evt_wdt = 1'b0;
    logic [4:0] irq_mask = 5'b0;
    logic reg_wr = 1'b0;
    logic path_en, int_n, wdt_force;

    int errors = 0, checks = 0;
    int pulses = 0, last_width = 0, last_gap = 0, low_run = 0, high_run = 1000;
    logic prev_n = 1'b1;
    logic [1:0] div = 2'd0;

    supply_irq_top #(.QUAL_TICKS(QUAL), .STABLE_TICKS(STABLE),
                     .PULSE_CYC(PULSE), .GAP_CYC(GAP)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .above_uvlo(above_uvlo),
        .below_ovlo(below_ovlo), .evt_done(evt_done), .evt_stat(evt_stat),
        .evt_fault(evt_fault), .evt_wdt(evt_wdt), .irq_mask(irq_mask),
        .reg_wr(reg_wr), .path_en(path_en), .int_n(int_n), .wdt_force(wdt_force)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        div     <= div + 2'd1;
        tick_ms <= (div == 2'd3);
    end

    always @(negedge clk) begin
        if (!rst_n) begin
            pulses = 0; low_run = 0; high_run = 1000; prev_n = 1'b1;
        end else begin
            if (!int_n) begin
                if (prev_n) begin
                    pulses++;
                    last_gap = high_run;
                end
                low_run++;
            end else begin
                if (!prev_n) begin
                    last_width = low_run;
                    high_run = 0;
                end
                low_run = 0;
                high_run++;
            end
            prev_n = int_n;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic strobe(input int which);
        @(negedge clk);
        case (which)
            1: evt_done = 1'b1;
            2: evt_stat = 1'b1;
            3: evt_fault = 1'b1;
            4: evt_wdt = 1'b1;
            default: begin evt_stat = 1'b1; evt_wdt = 1'b1; end
        endcase
        @(negedge clk);
        evt_done = 1'b0; evt_stat = 1'b0; evt_fault = 1'b0; evt_wdt = 1'b0;
    endtask

    task automatic t_reset();
        wait_cyc(3);
        check("R9 path_en", path_en, 0);
        check("R9 int_n", int_n, 1);
        check("R9 wdt_force", wdt_force, 0);
    endtask

    task automatic t_glitch();
        above_uvlo = 1'b1;
        wait_cyc(6);
        check("R2 short in-range no path", path_en, 0);
        above_uvlo = 1'b0;
        wait_cyc(60);
        check("R3 short state no report", pulses, 0);
    endtask

    task automatic t_plug();
        above_uvlo = 1'b1;
        wait_cyc(10);
        check("R2 path before qual", path_en, 0);
        wait_cyc(12);
        check("R2 path after qual", path_en, 1);
        check("R8 force on path close", wdt_force, 1);
        wait_cyc(60);
        check("R3 stable change reported", pulses, 1);
        check("R4 pulse width", last_width, PULSE);
        above_uvlo = 1'b0;
        #1;
        check("R1 path opens same cycle", path_en, 0);
        @(negedge clk);
        above_uvlo = 1'b1;
        #1;
        check("R2 requal needed", path_en, 0);
        wait_cyc(30);
        check("R2 path back after requal", path_en, 1);
        wait_cyc(40);
        check("R3 one-cycle dropout not reported", pulses, 1);
        over_vcheck();
    endtask

    task automatic over_vcheck();
        below_ovlo = 1'b0;
        #1;
        check("R1 over-voltage opens path", path_en, 0);
        @(negedge clk);
        below_ovlo = 1'b1;
        wait_cyc(30);
    endtask

    task automatic t_wr();
        @(negedge clk); reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
        check("R8 write clears force", wdt_force, 0);
    endtask

    task automatic t_events();
        int p0;
        p0 = pulses;
        strobe(1);
        wait_cyc(20);
        check("R5 charge complete pulse", pulses - p0, 1);
        check("R8 force on pulse", wdt_force, 1);
        check("R4 width event pulse", last_width, PULSE);
        strobe(3);
        wait_cyc(20);
        check("R5 fault pulse", pulses - p0, 2);
    endtask

    task automatic t_mask();
        int p0;
        p0 = pulses;
        irq_mask = 5'b01000;
        strobe(3);
        wait_cyc(20);
        check("R6 masked fault", pulses - p0, 0);
        check("R6 int_n high", int_n, 1);
        irq_mask = 5'b00001;
        above_uvlo = 1'b0;
        wait_cyc(60);
        check("R6 masked input report", pulses - p0, 0);
        irq_mask = 5'b00000;
        wait_cyc(10);
        check("R6 masked event discarded", pulses - p0, 0);
    endtask

    task automatic t_queue();
        int p0;
        p0 = pulses;
        strobe(5);
        wait_cyc(30);
        check("R7 simultaneous events two pulses", pulses - p0, 2);
        check("R7 gap length", (last_gap >= GAP) ? 1 : 0, 1);
        strobe(1);
        wait_cyc(2);
        strobe(2);
        wait_cyc(30);
        check("R7 event during pulse queued", pulses - p0, 4);
        check("R7 gap after queued", (last_gap >= GAP) ? 1 : 0, 1);
    endtask

    task automatic run_all();
        t_reset();
        t_glitch();
        t_plug();
        t_wr();
        t_events();
        t_mask();
        t_queue();
    endtask

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        fork
            run_all();
            begin
                repeat (20000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog: actual=expired expected=completed");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule